// File: doc/BRIEF.md
# SPI Serial Read-Only Memory Slave

This block is the serial front end of a read-only store of 16M bytes. A host reaches it over a four-wire SPI link. The host selects it by pulling the active-low select down. It then clocks in a one-byte command and a 24-bit start address, most significant bit first. It then clocks out as many data bytes as it wants. Input bits are taken on the rising serial clock edge and output bits change after the falling edge, so both idle-low (mode 0) and idle-high (mode 3) hosts work.

Two commands read the store. The plain read (0x03) starts returning data right after the last address bit. The fast read (0x0B) inserts eight dummy clocks, whose data is disregarded, before data begins. The read address moves up by one after every full byte and folds back from the top of the space to zero, so a stream has no natural end. The host ends it by raising select at any bit.

All logic runs on the serial clock. Select high acts as an asynchronous reset. The array content is a fixed function of the address, computed rather than stored. The serial output has a separate enable so that it can drive a shared, tri-stated line.

Top module: `spi_rom_slave`

## Requirements
- R1: While `cs_n` is high, `miso_oe` is 0 and the command state is cleared. After select first falls, `miso_oe` stays 0 until data output begins.
- R2: The command byte is captured most significant bit first, starting on the first rising `sclk` edge after `cs_n` falls. For command 0x03, the next 24 rising edges capture the address from bit 23 down to bit 0. Bit 7 of the first data byte is driven on the falling edge that directly follows the last address bit.
- R3: For command 0x0B, the 24 address bits are followed by 8 dummy bits whose values are ignored. The first data bit is driven on the falling edge after the eighth dummy bit.
- R4: Data bytes leave most significant bit first, one bit per falling `sclk` edge, with `miso_oe` at 1 for every data bit.
- R5: After each complete data byte the read address goes up by one, and the stream continues for as long as the host keeps clocking.
- R6: The byte after address 0xFFFFFF is the byte at address 0x000000.
- R7: Any command byte other than 0x03 or 0x0B makes the block ignore every later clock, with `miso_oe` held at 0, until `cs_n` rises.
- R8: Raising `cs_n` at any bit position, in the address phase or mid-byte in the data phase, ends the transfer. The next falling edge of `cs_n` starts a fresh command decode.
- R9: The byte stored at address A equals A[23:16] XOR A[15:8] XOR A[7:0] XOR 0x5A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock; inputs captured on rising edge, output changed on falling edge |
| cs_n | input | 1 | Active-low select; high acts as asynchronous reset |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | High while `miso` must be driven onto the line |

## Verification
The case hardest to reach from the ports is the address crossing from 0xFFFFFF to zero in the middle of a stream. It only happens after a start address near the top of the space and several bytes of continuous clocking. The bench starts reads a few bytes below the top with both commands and keeps clocking across the fold. Cutting a transfer off partway through is also awkward to reach. The bench raises select after a few bits of the address or of a data byte, checks that the output turns off, and then confirms that the next command decodes cleanly from a new address. A sweep of short reads over spread-out addresses and varied dummy values, plus a long stream across a low-byte carry, compares each byte with the content formula restated in the bench.

// File: rtl/spi_rom_pkg.sv
`timescale 1ns/1ps
package spi_rom_pkg;

  typedef enum logic [2:0] {
    PH_OPCODE = 3'd0,
    PH_ADDR   = 3'd1,
    PH_DUMMY  = 3'd2,
    PH_DATA   = 3'd3,
    PH_IGNORE = 3'd4
  } phase_t;

  localparam logic [7:0] CMD_READ = 8'h03;
  localparam logic [7:0] CMD_FAST = 8'h0B;

  // Stored content: XOR-fold of the address bytes, then a fixed mask.
  function automatic logic [7:0] rom_byte(input logic [31:0] a);
    logic [7:0] acc;
    acc = 8'h5A;
    for (int k = 0; k < 4; k++) acc = acc ^ a[8*k +: 8];
    return acc;
  endfunction

  function automatic logic is_read_cmd(input logic [7:0] op);
    return (op == CMD_READ) || (op == CMD_FAST);
  endfunction

endpackage

// File: rtl/spi_rom_seq.sv
`timescale 1ns/1ps
module spi_rom_seq
  import spi_rom_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DUMMY_BITS = 8
) (
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       mosi,
  output phase_t     phase,
  output logic [2:0] bit_idx,
  output logic       op_done,
  output logic [7:0] op_byte,
  output logic       addr_shift,
  output logic       byte_done,
  output logic       is_fast
);
  localparam int CNT_W = $clog2(ADDR_W > DUMMY_BITS ? ADDR_W : DUMMY_BITS) + 1;
  localparam logic [CNT_W-1:0] LAST_OP    = CNT_W'(7);
  localparam logic [CNT_W-1:0] LAST_ADDR  = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] LAST_DUMMY = CNT_W'(DUMMY_BITS - 1);

  logic [CNT_W-1:0] cnt;
  logic [6:0]       sr;

  assign op_byte    = {sr, mosi};
  assign op_done    = (phase == PH_OPCODE) && (cnt == LAST_OP);
  assign addr_shift = (phase == PH_ADDR);
  assign byte_done  = (phase == PH_DATA) && (cnt[2:0] == 3'd7);
  assign bit_idx    = cnt[2:0];

  always_ff @(posedge sclk or posedge cs_n) begin
    if (cs_n) begin
      phase   <= PH_OPCODE;
      cnt     <= '0;
      sr      <= '0;
      is_fast <= 1'b0;
    end else begin
      case (phase)
        PH_OPCODE: begin
          sr <= op_byte[6:0];
          if (op_done) begin
            cnt     <= '0;
            is_fast <= (op_byte == CMD_FAST);
            phase   <= is_read_cmd(op_byte) ? PH_ADDR : PH_IGNORE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_ADDR: begin
          if (cnt == LAST_ADDR) begin
            cnt   <= '0;
            phase <= is_fast ? PH_DUMMY : PH_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_DUMMY: begin
          if (cnt == LAST_DUMMY) begin
            cnt   <= '0;
            phase <= PH_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_DATA: cnt <= byte_done ? '0 : cnt + 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/spi_rom_addr.sv
`timescale 1ns/1ps
module spi_rom_addr #(
  parameter int ADDR_W = 24
) (
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  input  logic              shift_en,
  input  logic              step_en,
  output logic [ADDR_W-1:0] addr
);
  function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  always_ff @(posedge sclk or posedge cs_n) begin
    if (cs_n)          addr <= '0;
    else if (shift_en) addr <= {addr[ADDR_W-2:0], mosi};
    else if (step_en)  addr <= next_addr(addr);
  end
endmodule

// File: rtl/spi_rom_tx.sv
`timescale 1ns/1ps
module spi_rom_tx
  import spi_rom_pkg::*;
(
  input  logic       sclk,
  input  logic       cs_n,
  input  phase_t     phase,
  input  logic [2:0] bit_idx,
  input  logic [7:0] data,
  output logic       miso,
  output logic       miso_oe
);
  logic in_data;
  assign in_data = (phase == PH_DATA);

  always_ff @(negedge sclk or posedge cs_n) begin
    if (cs_n) begin
      miso    <= 1'b0;
      miso_oe <= 1'b0;
    end else begin
      miso_oe <= in_data;
      miso    <= in_data ? data[3'd7 - bit_idx] : 1'b0;
    end
  end
endmodule

// File: rtl/spi_rom_slave.sv
`timescale 1ns/1ps
module spi_rom_slave
  import spi_rom_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DUMMY_BITS = 8
) (
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic miso,
  output logic miso_oe
);
  phase_t            phase;
  logic [2:0]        bit_idx;
  logic              op_done;
  logic [7:0]        op_byte;
  logic              addr_shift;
  logic              byte_done;
  logic              is_fast;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        rd_data;

  spi_rom_seq #(.ADDR_W(ADDR_W), .DUMMY_BITS(DUMMY_BITS)) u_seq (
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .phase(phase), .bit_idx(bit_idx), .op_done(op_done), .op_byte(op_byte),
    .addr_shift(addr_shift), .byte_done(byte_done), .is_fast(is_fast)
  );

  spi_rom_addr #(.ADDR_W(ADDR_W)) u_addr (
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .shift_en(addr_shift), .step_en(byte_done), .addr(addr)
  );

  assign rd_data = rom_byte(32'(addr));

  spi_rom_tx u_tx (
    .sclk(sclk), .cs_n(cs_n), .phase(phase), .bit_idx(bit_idx),
    .data(rd_data), .miso(miso), .miso_oe(miso_oe)
  );
endmodule

// File: rtl/spi_rom_chk.sv
`timescale 1ns/1ps
module spi_rom_chk
  import spi_rom_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input logic              sclk,
  input logic              cs_n,
  input logic              miso_oe,
  input phase_t            phase,
  input logic              op_done,
  input logic [7:0]        op_byte,
  input logic              byte_done,
  input logic              is_fast,
  input logic [ADDR_W-1:0] addr
);
  AST_DESEL_QUIET: assert property (@(posedge sclk) cs_n |-> !miso_oe); // R1

  AST_OE_IN_DATA: assert property (@(posedge sclk) disable iff (cs_n)
    miso_oe |-> (phase == PH_DATA)); // R4

  AST_DUMMY_FAST: assert property (@(posedge sclk) disable iff (cs_n)
    (phase == PH_DUMMY) |-> is_fast); // R3

  AST_ADDR_STEP: assert property (@(posedge sclk) disable iff (cs_n)
    byte_done |=> (addr == ADDR_W'($past(addr) + 1'b1))); // R5

  AST_ADDR_HOLD: assert property (@(posedge sclk) disable iff (cs_n)
    ((phase == PH_DATA) && !byte_done) |=> $stable(addr)); // R5

  AST_BAD_OP_LOCK: assert property (@(posedge sclk) disable iff (cs_n)
    (op_done && (op_byte != CMD_READ) && (op_byte != CMD_FAST)) |=> (phase == PH_IGNORE)); // R7

  AST_IGNORE_STAYS: assert property (@(posedge sclk) disable iff (cs_n)
    (phase == PH_IGNORE) |=> ((phase == PH_IGNORE) && !miso_oe)); // R7
endmodule

bind spi_rom_slave spi_rom_chk #(.ADDR_W(ADDR_W)) u_chk (
  .sclk(sclk), .cs_n(cs_n), .miso_oe(miso_oe), .phase(phase),
  .op_done(op_done), .op_byte(op_byte), .byte_done(byte_done),
  .is_fast(is_fast), .addr(addr)
);

// File: tb/sim_spi_rom_slave.sv
`timescale 1ns/1ps
module sim_spi_rom_slave;
  localparam real CLK_HALF = 2.0;   // 250 MHz serial clock

  logic sclk = 1'b0;
  logic cs_n = 1'b0;
  logic mosi = 1'b0;
  logic miso;
  logic miso_oe;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  spi_rom_slave u0 (.sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso), .miso_oe(miso_oe));

  initial begin
    #1 cs_n = 1'b1;
    #3;
    forever #(CLK_HALF) sclk = ~sclk;
  end

  // Expected content per R9, written as a plain three-way XOR.
  function automatic logic [7:0] expect_at(input logic [23:0] a);
    return (a[23:16] ^ a[15:8]) ^ (a[7:0] ^ 8'h5A);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic begin_cmd();
    @(posedge sclk);
    #1 cs_n = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      @(negedge sclk);
      mosi = b[i];
    end
  endtask

  task automatic deselect(input string req);
    cs_n = 1'b1;
    #0.5;
    chk(miso_oe == 1'b0, req, miso_oe, 0);
  endtask

  task automatic run_read(input logic [7:0] opc, input logic [23:0] a, input logic [7:0] dum,
                          input int nbytes, input int extra_bits, input string req);
    logic [7:0]  got;
    logic [7:0]  exp;
    logic [23:0] cur;
    bit          oe_ok;
    begin_cmd();
    send_byte(opc);
    send_byte(a[23:16]);
    send_byte(a[15:8]);
    send_byte(a[7:0]);
    if (opc == 8'h0B) send_byte(dum);
    for (int j = 0; j < nbytes; j++) begin
      cur   = a + 24'(j);
      exp   = expect_at(cur);
      oe_ok = 1'b1;
      for (int i = 7; i >= 0; i--) begin
        @(negedge sclk);
        #1;
        got[i] = miso;
        if (miso_oe !== 1'b1) oe_ok = 1'b0;
      end
      chk((got == exp) && oe_ok, req, {oe_ok, got}, {1'b1, exp});
    end
    if (extra_bits > 0) begin
      cur = a + 24'(nbytes);
      exp = expect_at(cur);
      got = '0;
      for (int i = 7; i > 7 - extra_bits; i--) begin
        @(negedge sclk);
        #1;
        got[i] = miso;
      end
      chk((got >> (8 - extra_bits)) == (exp >> (8 - extra_bits)), {req, " partial"},
          got >> (8 - extra_bits), exp >> (8 - extra_bits));
    end
    deselect({req, " R1 R8 deselect"});
  endtask

  task automatic bad_cmd(input logic [7:0] opc);
    bit seen;
    begin_cmd();
    send_byte(opc);
    seen = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge sclk);
      mosi = i[0];
      #1;
      if (miso_oe !== 1'b0) seen = 1'b1;
    end
    chk(!seen, "R7 unknown command keeps output off", seen, 0);
    deselect("R7 R1 deselect after unknown command");
  endtask

  initial begin
    #(CLK_HALF * 2.0 * 100000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #2;
    chk(miso_oe == 1'b0, "R1 reset state", miso_oe, 0);
    #10;

    // R2 R3 R4 R9: short reads at spread-out addresses, both commands
    for (int k = 0; k < 16; k++) begin
      logic [23:0] a;
      a = 24'(k * 24'h111111) ^ 24'(k * 7);
      run_read(8'h03, a, 8'h00, 3, 0, "R2 R4 R9 read sweep");
      run_read(8'h0B, a, ~a[7:0], 3, 0, "R3 R4 R9 fast sweep");
    end

    // R3: dummy value ignored
    run_read(8'h0B, 24'h123456, 8'hFF, 2, 0, "R3 dummy ones");
    run_read(8'h0B, 24'h123456, 8'h03, 2, 0, "R3 dummy looks like command");

    // R6: wrap across the top of the space
    run_read(8'h03, 24'hFFFFFC, 8'h00, 8, 0, "R6 wrap read");
    run_read(8'h0B, 24'hFFFFFF, 8'hA5, 3, 0, "R6 wrap fast");

    // R5: long stream across a carry
    run_read(8'h03, 24'h00FF80, 8'h00, 260, 0, "R5 long stream");

    // R8: early deselect in data, then fresh commands
    run_read(8'h03, 24'h345678, 8'h00, 2, 3, "R8 early stop read");
    run_read(8'h0B, 24'h000010, 8'hFF, 1, 5, "R8 early stop fast");
    run_read(8'h03, 24'hABCDEF, 8'h00, 2, 0, "R8 restart after stop");

    // R8: abort in the address phase
    begin_cmd();
    send_byte(8'h03);
    send_byte(8'h12);
    for (int i = 0; i < 3; i++) begin
      @(negedge sclk);
      mosi = 1'b1;
    end
    #1;
    deselect("R8 abort in address");
    run_read(8'h0B, 24'h7FFFFF, 8'h00, 2, 0, "R8 restart after address abort");

    // R7: unrecognised commands, each followed by a valid one
    bad_cmd(8'h9F);
    run_read(8'h03, 24'h000001, 8'h00, 1, 0, "R7 R8 recovery");
    bad_cmd(8'h02);
    bad_cmd(8'h0A);
    bad_cmd(8'hFF);
    run_read(8'h0B, 24'hFEDCBA, 8'h00, 1, 0, "R7 R8 recovery fast");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule